// File: doc/BRIEF.md
# Last-Level Address Invalidate TLB

This block is a small fully associative stage 1 translation cache that can drop cached translations for one virtual page in a single clock. Each entry holds a virtual page number, a physical page number, an address space identifier, a virtual machine identifier, and flags for global, final lookup level, secure regime and stage 2. Entries are loaded through a fill port and read through a lookup port. The lookup port lets a caller see which translations survive an invalidation.

An invalidation request carries a 32-bit operand together with the requester's VMID, its security state and a hypervisor-active flag. The block clears the valid bit of every entry that meets all of these conditions:

- the entry is a stage 1 entry;
- the entry came from the final lookup level;
- the entry's page matches the operand;
- the entry is global, or its ASID matches the operand;
- the entry's VMID matches, if a hypervisor is active;
- the entry's regime matches the requester's security state.

Each local request is sent one cycle later on an outgoing snoop port, so that peer caches in the same inner shareable domain apply the same invalidation. Requests that arrive from peers on the incoming snoop port are applied in the same way.

Top module: `tlb_inval_engine`

## Requirements
- R1: The invalidate operand holds the virtual page number in bits [31:12] and the ASID in bits [7:0]. Bits [11:8] are ignored for matching.
- R2: Entries flagged stage 2 are never cleared by an invalidation.
- R3: Entries whose final-level flag is 0 are never cleared by an invalidation.
- R4: A global stage 1 final-level entry whose page matches is cleared whatever ASID the operand holds.
- R5: A non-global entry is cleared only when both its page and its ASID equal the operand's.
- R6: When the hypervisor-active flag is 1, an entry is cleared only if its VMID equals the request VMID. When the flag is 0, VMID plays no part in the match.
- R7: A request is applied only to entries whose secure flag equals the request's security state (1 means secure, 0 means non-secure).
- R8: One cycle after a local request, `inv_done_o` pulses for one cycle. In that same cycle the outgoing snoop port presents the operand, VMID, security state and hypervisor flag of that request.
- R9: A request on the incoming snoop port is applied with the same matching rules. It produces neither a done pulse nor an outgoing snoop.
- R10: Matching entries are cleared at the clock edge that ends the request cycle. A lookup made in the request cycle that would hit a matching entry reports a miss.
- R11: The cache holds 16 entries, and reset clears every valid bit. Fills go to slots in round-robin order starting at slot 0. A slot filled in the same cycle as an invalidation keeps the new entry.
- R12: A lookup hits when a valid entry has the lookup's page, stage 2 flag, final-level flag, secure flag and VMID, and is either global or has the lookup's ASID. When several entries hit, the lowest index wins. The physical address is the entry's page number above bits [11:0] of the lookup address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fill_valid_i | input | 1 | Write a new entry at the replacement slot |
| fill_vpn_i | input | 20 | Virtual page number of the new entry |
| fill_ppn_i | input | 20 | Physical page number of the new entry |
| fill_asid_i | input | 8 | ASID of the new entry |
| fill_vmid_i | input | 8 | VMID of the new entry |
| fill_global_i | input | 1 | New entry is global |
| fill_last_i | input | 1 | New entry is from the final lookup level |
| fill_secure_i | input | 1 | New entry belongs to the secure regime |
| fill_stage2_i | input | 1 | New entry is a stage 2 entry |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_va_i | input | 32 | Lookup virtual address |
| lkp_asid_i | input | 8 | Lookup ASID |
| lkp_vmid_i | input | 8 | Lookup VMID |
| lkp_secure_i | input | 1 | Lookup regime |
| lkp_last_i | input | 1 | Final-level flag to match |
| lkp_stage2_i | input | 1 | Stage 2 flag to match |
| lkp_hit_o | output | 1 | Lookup hit |
| lkp_pa_o | output | 32 | Translated physical address |
| inv_valid_i | input | 1 | Local invalidate request |
| inv_op_i | input | 32 | Invalidate operand |
| inv_vmid_i | input | 8 | Requester VMID |
| inv_secure_i | input | 1 | Requester security state |
| inv_hyp_i | input | 1 | Hypervisor active for requester |
| inv_done_o | output | 1 | Local invalidate complete |
| snp_out_valid_o | output | 1 | Broadcast request to peers |
| snp_out_op_o | output | 32 | Broadcast operand |
| snp_out_vmid_o | output | 8 | Broadcast VMID |
| snp_out_secure_o | output | 1 | Broadcast security state |
| snp_out_hyp_o | output | 1 | Broadcast hypervisor flag |
| snp_in_valid_i | input | 1 | Request from a peer |
| snp_in_op_i | input | 32 | Peer operand |
| snp_in_vmid_i | input | 8 | Peer VMID |
| snp_in_secure_i | input | 1 | Peer security state |
| snp_in_hyp_i | input | 1 | Peer hypervisor flag |

## Verification
Some rules are checked by assertions on every cycle:

- stage 2 entries and non-final-level entries survive every request;
- every entry flagged for clearing is invalid after the edge;
- a request is followed by the done pulse and the broadcast;
- an incoming snoop alone is never rebroadcast;
- a same-cycle lookup of the invalidated page never hits.

The finer selection rules can only be shown by the bench's scenarios, which compare the surviving entries against a model, seen through lookups. These rules are the ASID and global rule, VMID matching that depends on the hypervisor flag, regime selection, the ignored reserved bits, round-robin slot order, and a fill that coincides with an invalidation.

// File: rtl/tlb_inval_pkg.sv
package tlb_inval_pkg;
  localparam int VA_W     = 32;
  localparam int PG_SHIFT = 12;
  localparam int VPN_W    = VA_W - PG_SHIFT;
  localparam int PPN_W    = 20;
  localparam int ASID_W   = 8;
  localparam int VMID_W   = 8;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic [ASID_W-1:0] asid;
    logic [VMID_W-1:0] vmid;
    logic              global;
    logic              last;
    logic              secure;
    logic              stage2;
  } tlb_entry_t;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [VMID_W-1:0] vmid;
    logic              secure;
    logic              hyp;
  } inv_req_t;
endpackage

// File: rtl/tlb_inv_match.sv
module tlb_inv_match
  import tlb_inval_pkg::*;
#(
  parameter int N_ENTRIES = 16
) (
  input  logic                         req_valid_i,
  input  inv_req_t                     req_i,
  input  tlb_entry_t [N_ENTRIES-1:0]   ent_i,
  input  logic       [N_ENTRIES-1:0]   vld_i,
  output logic       [N_ENTRIES-1:0]   kill_o
);
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    logic kind_ok, va_ok, asid_ok, vmid_ok, reg_ok;
    always_comb begin
      kind_ok   = !ent_i[g].stage2 && ent_i[g].last;
      va_ok     = ent_i[g].vpn == req_i.vpn;
      asid_ok   = ent_i[g].global || (ent_i[g].asid == req_i.asid);
      vmid_ok   = !req_i.hyp || (ent_i[g].vmid == req_i.vmid);
      reg_ok    = ent_i[g].secure == req_i.secure;
      kill_o[g] = req_valid_i && vld_i[g] && kind_ok && va_ok && asid_ok
                  && vmid_ok && reg_ok;
    end
  end
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_inval_pkg::*;
#(
  parameter int N_ENTRIES = 16
) (
  input  tlb_entry_t [N_ENTRIES-1:0] ent_i,
  input  logic       [N_ENTRIES-1:0] vld_i,
  input  logic       [N_ENTRIES-1:0] kill_i,
  input  logic                       lkp_valid_i,
  input  logic       [VPN_W-1:0]     lkp_vpn_i,
  input  logic       [ASID_W-1:0]    lkp_asid_i,
  input  logic       [VMID_W-1:0]    lkp_vmid_i,
  input  logic                       lkp_secure_i,
  input  logic                       lkp_last_i,
  input  logic                       lkp_stage2_i,
  output logic                       hit_o,
  output logic       [PPN_W-1:0]     ppn_o
);
  logic [N_ENTRIES-1:0] hit_vec;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    always_comb
      hit_vec[g] = lkp_valid_i && vld_i[g] && !kill_i[g]
                   && ent_i[g].vpn == lkp_vpn_i
                   && ent_i[g].stage2 == lkp_stage2_i
                   && ent_i[g].last == lkp_last_i
                   && ent_i[g].secure == lkp_secure_i
                   && ent_i[g].vmid == lkp_vmid_i
                   && (ent_i[g].global || ent_i[g].asid == lkp_asid_i);
  end

  // lowest index wins
  always_comb begin
    ppn_o = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) ppn_o = ent_i[i].ppn;
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end

  p_ptr_range_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o <= LAST);
endmodule

// File: rtl/tlb_inval_engine.sv
module tlb_inval_engine
  import tlb_inval_pkg::*;
#(
  parameter int N_ENTRIES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_valid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [VMID_W-1:0] fill_vmid_i,
  input  logic              fill_global_i,
  input  logic              fill_last_i,
  input  logic              fill_secure_i,
  input  logic              fill_stage2_i,
  input  logic              lkp_valid_i,
  input  logic [VA_W-1:0]   lkp_va_i,
  input  logic [ASID_W-1:0] lkp_asid_i,
  input  logic [VMID_W-1:0] lkp_vmid_i,
  input  logic              lkp_secure_i,
  input  logic              lkp_last_i,
  input  logic              lkp_stage2_i,
  output logic              lkp_hit_o,
  output logic [VA_W-1:0]   lkp_pa_o,
  input  logic              inv_valid_i,
  input  logic [VA_W-1:0]   inv_op_i,
  input  logic [VMID_W-1:0] inv_vmid_i,
  input  logic              inv_secure_i,
  input  logic              inv_hyp_i,
  output logic              inv_done_o,
  output logic              snp_out_valid_o,
  output logic [VA_W-1:0]   snp_out_op_o,
  output logic [VMID_W-1:0] snp_out_vmid_o,
  output logic              snp_out_secure_o,
  output logic              snp_out_hyp_o,
  input  logic              snp_in_valid_i,
  input  logic [VA_W-1:0]   snp_in_op_i,
  input  logic [VMID_W-1:0] snp_in_vmid_i,
  input  logic              snp_in_secure_i,
  input  logic              snp_in_hyp_i
);
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
  localparam int N_SRC = 2;  // 0: local, 1: snoop

  tlb_entry_t [N_ENTRIES-1:0] ent_q;
  logic       [N_ENTRIES-1:0] vld_q, vld_d, kill_any;
  logic       [N_ENTRIES-1:0] kill [N_SRC];
  logic       [IDX_W-1:0]     ptr;
  logic       [PPN_W-1:0]     hit_ppn;
  inv_req_t                   req [N_SRC];
  logic                       req_v [N_SRC];

  // operand bits [11:8] are reserved and never decoded
  always_comb begin
    req[0]   = '{vpn: inv_op_i[VA_W-1:PG_SHIFT], asid: inv_op_i[ASID_W-1:0],
                 vmid: inv_vmid_i, secure: inv_secure_i, hyp: inv_hyp_i};
    req[1]   = '{vpn: snp_in_op_i[VA_W-1:PG_SHIFT], asid: snp_in_op_i[ASID_W-1:0],
                 vmid: snp_in_vmid_i, secure: snp_in_secure_i, hyp: snp_in_hyp_i};
    req_v[0] = inv_valid_i;
    req_v[1] = snp_in_valid_i;
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    tlb_inv_match #(.N_ENTRIES(N_ENTRIES)) u_match (
      .req_valid_i(req_v[s]),
      .req_i      (req[s]),
      .ent_i      (ent_q),
      .vld_i      (vld_q),
      .kill_o     (kill[s])
    );
  end

  assign kill_any = kill[0] | kill[1];

  tlb_rr_ptr #(.N_ENTRIES(N_ENTRIES)) u_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (fill_valid_i),
    .ptr_o (ptr)
  );

  always_comb begin
    vld_d = vld_q & ~kill_any;
    if (fill_valid_i) vld_d[ptr] = 1'b1;  // new entry beats same-cycle kill
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= vld_d;
  end

  always_ff @(posedge clk_i) begin
    if (fill_valid_i)
      ent_q[ptr] <= '{vpn: fill_vpn_i, ppn: fill_ppn_i, asid: fill_asid_i,
                      vmid: fill_vmid_i, global: fill_global_i, last: fill_last_i,
                      secure: fill_secure_i, stage2: fill_stage2_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_done_o       <= 1'b0;
      snp_out_valid_o  <= 1'b0;
      snp_out_op_o     <= '0;
      snp_out_vmid_o   <= '0;
      snp_out_secure_o <= 1'b0;
      snp_out_hyp_o    <= 1'b0;
    end else begin
      inv_done_o      <= inv_valid_i;
      snp_out_valid_o <= inv_valid_i;
      if (inv_valid_i) begin
        snp_out_op_o     <= inv_op_i;
        snp_out_vmid_o   <= inv_vmid_i;
        snp_out_secure_o <= inv_secure_i;
        snp_out_hyp_o    <= inv_hyp_i;
      end
    end
  end

  tlb_lookup #(.N_ENTRIES(N_ENTRIES)) u_lkp (
    .ent_i       (ent_q),
    .vld_i       (vld_q),
    .kill_i      (kill_any),
    .lkp_valid_i (lkp_valid_i),
    .lkp_vpn_i   (lkp_va_i[VA_W-1:PG_SHIFT]),
    .lkp_asid_i  (lkp_asid_i),
    .lkp_vmid_i  (lkp_vmid_i),
    .lkp_secure_i(lkp_secure_i),
    .lkp_last_i  (lkp_last_i),
    .lkp_stage2_i(lkp_stage2_i),
    .hit_o       (lkp_hit_o),
    .ppn_o       (hit_ppn)
  );

  assign lkp_pa_o = {hit_ppn, lkp_va_i[PG_SHIFT-1:0]};

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_chk
    p_kill_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      kill_any[g] && !(fill_valid_i && ptr == IDX_W'(g)) |=> !vld_q[g]);
    p_stage2_kept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_q[g] && ent_q[g].stage2 |=> vld_q[g]);
    p_walk_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_q[g] && !ent_q[g].last |=> vld_q[g]);
  end

  p_bcast_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_i |=> snp_out_valid_o && inv_done_o && snp_out_op_o == $past(inv_op_i));
  p_no_rebcast_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_in_valid_i && !inv_valid_i |=> !snp_out_valid_o && !inv_done_o);
  p_same_page_miss_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_i && lkp_valid_i && !lkp_stage2_i && lkp_last_i
    && lkp_va_i[VA_W-1:PG_SHIFT] == inv_op_i[VA_W-1:PG_SHIFT]
    && lkp_asid_i == inv_op_i[ASID_W-1:0] && lkp_secure_i == inv_secure_i
    && (!inv_hyp_i || lkp_vmid_i == inv_vmid_i) |-> !lkp_hit_o);
endmodule

// File: tb/tlb_inval_engine_test.sv
module tlb_inval_engine_test;
  localparam int N = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic        fill_v = 0, fill_g = 0, fill_l = 0, fill_s = 0, fill_s2 = 0;
  logic [19:0] fill_vpn = 0, fill_ppn = 0;
  logic [7:0]  fill_asid = 0, fill_vmid = 0;
  logic        lkp_v = 0, lkp_s = 0, lkp_l = 0, lkp_s2 = 0;
  logic [31:0] lkp_va = 0;
  logic [7:0]  lkp_asid = 0, lkp_vmid = 0;
  logic        lkp_hit;
  logic [31:0] lkp_pa;
  logic        inv_v = 0, inv_s = 0, inv_h = 0;
  logic [31:0] inv_op = 0;
  logic [7:0]  inv_vmid = 0;
  logic        done, so_v, so_s, so_h;
  logic [31:0] so_op;
  logic [7:0]  so_vmid;
  logic        si_v = 0, si_s = 0, si_h = 0;
  logic [31:0] si_op = 0;
  logic [7:0]  si_vmid = 0;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tlb_inval_engine uut (
    .clk_i(clk), .rst_ni(rst_n),
    .fill_valid_i(fill_v), .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn),
    .fill_asid_i(fill_asid), .fill_vmid_i(fill_vmid), .fill_global_i(fill_g),
    .fill_last_i(fill_l), .fill_secure_i(fill_s), .fill_stage2_i(fill_s2),
    .lkp_valid_i(lkp_v), .lkp_va_i(lkp_va), .lkp_asid_i(lkp_asid),
    .lkp_vmid_i(lkp_vmid), .lkp_secure_i(lkp_s), .lkp_last_i(lkp_l),
    .lkp_stage2_i(lkp_s2), .lkp_hit_o(lkp_hit), .lkp_pa_o(lkp_pa),
    .inv_valid_i(inv_v), .inv_op_i(inv_op), .inv_vmid_i(inv_vmid),
    .inv_secure_i(inv_s), .inv_hyp_i(inv_h), .inv_done_o(done),
    .snp_out_valid_o(so_v), .snp_out_op_o(so_op), .snp_out_vmid_o(so_vmid),
    .snp_out_secure_o(so_s), .snp_out_hyp_o(so_h),
    .snp_in_valid_i(si_v), .snp_in_op_i(si_op), .snp_in_vmid_i(si_vmid),
    .snp_in_secure_i(si_s), .snp_in_hyp_i(si_h)
  );

  // reference model
  bit        m_v [N];
  bit [19:0] m_vpn [N], m_ppn [N];
  bit [7:0]  m_asid [N], m_vmid [N];
  bit        m_g [N], m_l [N], m_s [N], m_s2 [N];
  int        m_ptr = 0;
  bit        p_inv = 0, p_h = 0, p_s = 0;
  bit [31:0] p_op = 0;
  bit [7:0]  p_vmid = 0;

  function automatic bit m_kill(int i, bit v, bit [31:0] op, bit [7:0] vm, bit s, bit h);
    return v && m_v[i] && !m_s2[i] && m_l[i] && m_vpn[i] == op[31:12]
           && (m_g[i] || m_asid[i] == op[7:0]) && (!h || m_vmid[i] == vm)
           && m_s[i] == s;
  endfunction

  function automatic bit kill_now(int i);
    return m_kill(i, inv_v, inv_op, inv_vmid, inv_s, inv_h)
        || m_kill(i, si_v, si_op, si_vmid, si_s, si_h);
  endfunction

  task automatic check(string tag, bit ok, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // inputs already driven after a negedge; check, clock, update model
  task automatic cyc(string tag);
    bit ehit = 0;
    bit [19:0] eppn = 0;
    #5;
    for (int i = N - 1; i >= 0; i--)
      if (lkp_v && m_v[i] && !kill_now(i) && m_vpn[i] == lkp_va[31:12]
          && m_s2[i] == lkp_s2 && m_l[i] == lkp_l && m_s[i] == lkp_s
          && m_vmid[i] == lkp_vmid && (m_g[i] || m_asid[i] == lkp_asid)) begin
        ehit = 1; eppn = m_ppn[i];
      end
    check({tag, " hit"}, lkp_hit === ehit, 32'(lkp_hit), 32'(ehit));
    if (ehit) check({tag, " pa R12"}, lkp_pa === {eppn, lkp_va[11:0]}, lkp_pa, {eppn, lkp_va[11:0]});
    check("R8 done", done === p_inv, 32'(done), 32'(p_inv));
    check("R8/R9 snoop out", so_v === p_inv, 32'(so_v), 32'(p_inv));
    if (p_inv)
      check("R8 snoop fields", {so_op, so_vmid, so_s, so_h} === {p_op, p_vmid, p_s, p_h},
            so_op, p_op);
    @(posedge clk);
    for (int i = 0; i < N; i++) if (kill_now(i)) m_v[i] = 0;
    if (fill_v) begin
      m_v[m_ptr] = 1; m_vpn[m_ptr] = fill_vpn; m_ppn[m_ptr] = fill_ppn;
      m_asid[m_ptr] = fill_asid; m_vmid[m_ptr] = fill_vmid; m_g[m_ptr] = fill_g;
      m_l[m_ptr] = fill_l; m_s[m_ptr] = fill_s; m_s2[m_ptr] = fill_s2;
      m_ptr = (m_ptr + 1) % N;
    end
    p_inv = inv_v; p_op = inv_op; p_vmid = inv_vmid; p_s = inv_s; p_h = inv_h;
    @(negedge clk);
    fill_v = 0; inv_v = 0; si_v = 0;
  endtask

  task automatic do_fill(bit [19:0] vpn, bit [19:0] ppn, bit [7:0] asid, bit [7:0] vm,
                         bit g, bit l, bit s, bit s2);
    fill_v = 1; fill_vpn = vpn; fill_ppn = ppn; fill_asid = asid; fill_vmid = vm;
    fill_g = g; fill_l = l; fill_s = s; fill_s2 = s2;
  endtask

  task automatic set_lkp(bit [19:0] vpn, bit [7:0] asid, bit [7:0] vm, bit s, bit l, bit s2);
    lkp_v = 1; lkp_va = {vpn, 12'h5a4}; lkp_asid = asid; lkp_vmid = vm;
    lkp_s = s; lkp_l = l; lkp_s2 = s2;
  endtask

  task automatic set_inv(bit [31:0] op, bit [7:0] vm, bit s, bit h);
    inv_v = 1; inv_op = op; inv_vmid = vm; inv_s = s; inv_h = h;
  endtask

  task automatic probe_all(string tag);
    for (int i = 0; i < N; i++) begin
      set_lkp(m_vpn[i], m_asid[i], m_vmid[i], m_s[i], m_l[i], m_s2[i]);
      cyc(tag);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit [31:0] r;
    for (int i = 0; i < N; i++) m_v[i] = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11 reset: empty cache, no pulses
    set_lkp(20'h0, 8'h0, 8'h0, 0, 1, 0);
    cyc("R11 reset");

    // slot layout, all page 0x00005
    do_fill(20'h5, 20'hA0000, 8'h11, 8'h0, 1, 1, 0, 0); cyc("R11 fill"); // 0 global
    do_fill(20'h5, 20'hA0001, 8'h22, 8'h0, 0, 1, 0, 0); cyc("R11 fill"); // 1 asid 22
    do_fill(20'h5, 20'hA0002, 8'h33, 8'h0, 0, 1, 0, 0); cyc("R11 fill"); // 2 asid 33
    do_fill(20'h5, 20'hA0003, 8'h22, 8'h0, 0, 1, 0, 1); cyc("R11 fill"); // 3 stage2
    do_fill(20'h5, 20'hA0004, 8'h22, 8'h0, 0, 0, 0, 0); cyc("R11 fill"); // 4 walk
    do_fill(20'h5, 20'hA0005, 8'h22, 8'h0, 0, 1, 1, 0); cyc("R11 fill"); // 5 secure
    do_fill(20'h5, 20'hA0006, 8'h22, 8'h07, 0, 1, 0, 0); cyc("R11 fill"); // 6 vmid 7
    do_fill(20'h6, 20'hA0007, 8'h22, 8'h0, 0, 1, 0, 0); cyc("R11 fill"); // 7 other page
    probe_all("R12 lookup");

    // R1 R10: reserved bits set, same-cycle lookup of slot 1 misses
    set_inv({20'h5, 4'hF, 8'h22}, 8'h0, 0, 0);
    set_lkp(20'h5, 8'h22, 8'h0, 0, 1, 0);
    cyc("R10 same-cycle R1");
    // R2 R3 R4 R5 R6 R7: survivors
    probe_all("R2 R3 R4 R5 R6 R7 survivors");

    // R6 with hypervisor on: vmid mismatch keeps, match clears
    do_fill(20'h9, 20'hB0000, 8'h01, 8'h03, 0, 1, 0, 0); cyc("R6 fill");
    do_fill(20'h9, 20'hB0001, 8'h01, 8'h04, 0, 1, 0, 0); cyc("R6 fill");
    set_inv({20'h9, 4'h0, 8'h01}, 8'h04, 0, 1); cyc("R6 hyp");
    probe_all("R6 hyp survivors");

    // R7 secure request only hits secure slot 5
    set_inv({20'h5, 4'h0, 8'h22}, 8'h0, 1, 0); cyc("R7 secure");
    probe_all("R7 after");

    // R9 incoming snoop applies, no done
    si_v = 1; si_op = {20'h6, 4'h3, 8'h22}; si_vmid = 0; si_s = 0; si_h = 0;
    set_lkp(20'h6, 8'h22, 8'h0, 0, 1, 0);
    cyc("R9 snoop in");
    set_lkp(20'h6, 8'h22, 8'h0, 0, 1, 0);
    cyc("R9 after");

    // R11 fill coinciding with kill of its own page
    do_fill(20'hC, 20'hC0000, 8'h02, 8'h0, 0, 1, 0, 0);
    set_inv({20'hC, 4'h0, 8'h02}, 8'h0, 0, 0);
    cyc("R11 fill vs kill");
    set_lkp(20'hC, 8'h02, 8'h0, 0, 1, 0);
    cyc("R11 fill kept");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      r = $urandom;
      if (r[1:0] == 0)
        do_fill({r[31] ? 20'h80000 : 20'h0} | 20'(r[3:2]), 20'($urandom),
                {7'h0, r[4]}, {7'h0, r[5]}, r[6], r[7] | r[8], r[9], r[10] & r[11]);
      if (r[14:12] == 0)
        set_inv({r[31] ? 12'h800 : 12'h000, 6'h0, r[16:15], r[20:17], 7'h0, r[21]},
                {7'h0, r[22]}, r[23], r[24]);
      else if (r[14:12] == 1) begin
        si_v = 1; si_op = {r[31] ? 12'h800 : 12'h000, 6'h0, r[16:15], 4'h0, 7'h0, r[21]};
        si_vmid = {7'h0, r[22]}; si_s = r[23]; si_h = r[24];
      end
      r = $urandom;
      if (inv_v && r[0]) set_lkp(inv_op[31:12], inv_op[7:0], r[8:1], inv_s, 1, 0);
      else set_lkp({r[31] ? 20'h80000 : 20'h0} | 20'(r[3:2]), {7'h0, r[4]},
                   {7'h0, r[5]}, r[9], r[7] | r[8], r[10] & r[11]);
      lkp_vmid = {7'h0, r[5]};
      cyc("R12 random R4 R5 R6 R7");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule